// File: doc/BRIEF.md
# Initializing Store Miss Filter

This block sits beside the outgoing memory request queue of a write-allocating cache hierarchy. It keeps a small, fully-associative table of cache-block addresses that a separate range tracker has marked as about to receive their first write. The tracker supplies these addresses. Each one is a complete physical address built from the translated tag and the store's offset.

A store can miss every cache level while at least one level allocates on write. In that case the fetch request enters the memory request queue, and in the same cycle the filter is probed with the store's address and the queue slot identifier. If the block is in the table, the filter tells the queue to drop that slot. The entry then waits for write permission on the block. Once permission arrives, the filter tells the cache to install the whole block as zeros and frees the entry. The store therefore never causes a bus transfer.

If the probe finds no matching entry, nothing happens and the fetch goes ahead. The table has a fixed capacity. When it is full, a new address replaces the oldest entry that is not waiting for permission.

Top module: `init_miss_filter`

## Requirements
- R1: After reset the table is empty: no cancel or install is issued, and a probe of any address produces no cancel.
- R2: A probe whose block matches an armed entry raises `cancel_valid` in the next cycle, with `cancel_qid` equal to the probed queue identifier.
- R3: A probe that matches no armed entry raises neither `cancel_valid` nor `install_valid` in the next cycle, and it leaves the table unchanged.
- R4: An install is issued only after a grant. A grant whose block matches an entry that is waiting for permission raises `install_valid` in the next cycle. `install_addr` carries the block address with its low log2(BLOCK_BYTES) bits at zero.
- R5: After its install, an entry is removed, so a later probe of that block produces no cancel.
- R6: An entry waiting for permission does not match a further probe.
- R7: Inserting a block that already has an entry changes nothing, so the table keeps a single entry for it and that entry keeps its original age.
- R8: An insert into a full table whose entries are all armed replaces the entry that was inserted longest ago.
- R9: Entries waiting for permission are never replaced. An insert that arrives while every entry is waiting is dropped.
- R10: A grant for a block that has no entry waiting for permission issues no install. An armed entry for that block stays armed.
- R11: Matching compares whole cache blocks. Addresses that differ only in the low log2(BLOCK_BYTES) bits match, and addresses that differ in any higher bit do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert a flagged address this cycle |
| ins_addr | input | ADDR_W | Physical address of the flagged store |
| probe_valid | input | 1 | Store missed all levels; its fetch is being queued |
| probe_addr | input | ADDR_W | Physical address of the missing store |
| probe_qid | input | QID_W | Request queue slot holding the fetch |
| grant_valid | input | 1 | Write permission has been granted for a block |
| grant_addr | input | ADDR_W | Address of the block that was granted |
| cancel_valid | output | 1 | Drop the queued fetch named by cancel_qid |
| cancel_qid | output | QID_W | Queue slot to drop |
| install_valid | output | 1 | Install a zero-filled block in the cache |
| install_addr | output | ADDR_W | Block-aligned address to install |

## Verification
The hardest situation to reach is a full table in which some or all entries are waiting for permission. Reaching it means that eviction has to skip the waiting entries, and when every entry is waiting, an insert has to be dropped. The stimulus gets there in directed phases that start from a fresh reset. One phase fills all slots and then probes every block into the waiting state before inserting once more. Another overfills a table of armed entries and includes a duplicate insert. After the directed phases, a long random run draws from a pool of blocks only slightly larger than the capacity. This mixes inserts, probes and grants so that eviction, merging and freeing interleave. A bench-side model that tracks insertion order predicts every output.

// File: rtl/ismf_pkg.sv
package ismf_pkg;

    // Lifecycle of one table slot.
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,   // unused
        SLOT_ARMED = 2'd1,   // flagged block, waiting for a miss probe
        SLOT_HELD  = 2'd2    // fetch cancelled, waiting for write permission
    } slot_state_e;

    localparam int unsigned DEF_ADDR_W      = 40;
    localparam int unsigned DEF_BLOCK_BYTES = 64;
    localparam int unsigned DEF_ENTRIES     = 16;
    localparam int unsigned DEF_QID_W       = 6;

    function automatic bit is_live(slot_state_e s);
        return s != SLOT_EMPTY;
    endfunction

endpackage

// File: rtl/ismf_cam.sv
module ismf_cam #(
    parameter int unsigned N = 16,
    parameter int unsigned W = 34
) (
    input  logic [N-1:0][W-1:0] keys,
    input  logic [N-1:0]        live,
    input  logic [W-1:0]        key,
    output logic [N-1:0]        hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = live[g] && (keys[g] == key);
    end
endmodule

// File: rtl/ismf_enc.sv
module ismf_enc #(
    parameter int unsigned N  = 16,
    parameter int unsigned IW = 4
) (
    input  logic [N-1:0]  onehot,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/ismf_victim.sv
module ismf_victim #(
    parameter int unsigned N  = 16,
    parameter int unsigned IW = 4
) (
    input  logic [N-1:0]         empty,
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][IW-1:0] rank,
    output logic [IW-1:0]        idx,
    output logic                 ok,
    output logic                 replace
);
    logic          have_empty;
    logic [IW-1:0] best;

    always_comb begin
        idx        = '0;
        have_empty = 1'b0;
        ok         = 1'b0;
        replace    = 1'b0;
        best       = '0;
        // lowest free slot first
        for (int i = N - 1; i >= 0; i--) begin
            if (empty[i]) begin
                idx        = IW'(i);
                have_empty = 1'b1;
            end
        end
        if (have_empty) begin
            ok = 1'b1;
        end else begin
            // otherwise the armed slot with the highest rank (oldest)
            for (int i = 0; i < N; i++) begin
                if (cand[i] && (!ok || rank[i] > best)) begin
                    idx  = IW'(i);
                    best = rank[i];
                    ok   = 1'b1;
                end
            end
            replace = ok;
        end
    end
endmodule

// File: rtl/init_miss_filter.sv
module init_miss_filter
    import ismf_pkg::*;
#(
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    parameter int unsigned BLOCK_BYTES = DEF_BLOCK_BYTES,
    parameter int unsigned ENTRIES     = DEF_ENTRIES,
    parameter int unsigned QID_W       = DEF_QID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              probe_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic [QID_W-1:0]  probe_qid,
    input  logic              grant_valid,
    input  logic [ADDR_W-1:0] grant_addr,
    output logic              cancel_valid,
    output logic [QID_W-1:0]  cancel_qid,
    output logic              install_valid,
    output logic [ADDR_W-1:0] install_addr
);
    localparam int unsigned OFF_W  = $clog2(BLOCK_BYTES);
    localparam int unsigned BLK_W  = ADDR_W - OFF_W;
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned RANK_W = IDX_W;

    typedef struct packed {
        slot_state_e       st;
        logic [BLK_W-1:0]  blk;
        logic [RANK_W-1:0] rank;   // 0 = newest live slot
    } slot_t;

    slot_t tab_q [ENTRIES];
    slot_t tab_d [ENTRIES];

    logic [BLK_W-1:0] ins_blk, probe_blk, grant_blk;
    assign ins_blk   = ins_addr[ADDR_W-1:OFF_W];
    assign probe_blk = probe_addr[ADDR_W-1:OFF_W];
    assign grant_blk = grant_addr[ADDR_W-1:OFF_W];

    logic unused_low;
    assign unused_low = ^{ins_addr[OFF_W-1:0], probe_addr[OFF_W-1:0], grant_addr[OFF_W-1:0]};

    logic [ENTRIES-1:0][BLK_W-1:0]  keys;
    logic [ENTRIES-1:0][RANK_W-1:0] ranks;
    logic [ENTRIES-1:0] live_any, live_armed, live_held, empty_v, cand_v;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_view
        assign keys[g]       = tab_q[g].blk;
        assign ranks[g]      = tab_q[g].rank;
        assign live_any[g]   = is_live(tab_q[g].st);
        assign live_armed[g] = tab_q[g].st == SLOT_ARMED;
        assign live_held[g]  = tab_q[g].st == SLOT_HELD;
        assign empty_v[g]    = tab_q[g].st == SLOT_EMPTY;
    end

    logic [ENTRIES-1:0] ins_hit, probe_hit, grant_hit;

    ismf_cam #(.N(ENTRIES), .W(BLK_W)) u_cam_ins (
        .keys(keys), .live(live_any), .key(ins_blk), .hit(ins_hit));
    ismf_cam #(.N(ENTRIES), .W(BLK_W)) u_cam_probe (
        .keys(keys), .live(live_armed), .key(probe_blk), .hit(probe_hit));
    ismf_cam #(.N(ENTRIES), .W(BLK_W)) u_cam_grant (
        .keys(keys), .live(live_held), .key(grant_blk), .hit(grant_hit));

    logic [IDX_W-1:0] probe_idx, grant_idx, vic_idx;
    logic             vic_ok, vic_replace;

    ismf_enc #(.N(ENTRIES), .IW(IDX_W)) u_enc_probe (.onehot(probe_hit), .idx(probe_idx));
    ismf_enc #(.N(ENTRIES), .IW(IDX_W)) u_enc_grant (.onehot(grant_hit), .idx(grant_idx));

    // a slot being probed this cycle is not a replacement candidate
    assign cand_v = live_armed & ~(probe_valid ? probe_hit : '0);

    ismf_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim (
        .empty(empty_v), .cand(cand_v), .rank(ranks),
        .idx(vic_idx), .ok(vic_ok), .replace(vic_replace));

    logic probe_fire, grant_fire, ins_fire, ovw_fire;
    logic [RANK_W-1:0] grant_rank, vic_rank;

    assign probe_fire = probe_valid && (|probe_hit);
    assign grant_fire = grant_valid && (|grant_hit);
    assign ins_fire   = ins_valid && !(|ins_hit) && vic_ok;
    assign ovw_fire   = ins_fire && vic_replace;
    assign grant_rank = tab_q[grant_idx].rank;
    assign vic_rank   = tab_q[vic_idx].rank;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            logic [1:0] dec;
            tab_d[i] = tab_q[i];
            dec = 2'd0;
            if (is_live(tab_q[i].st)) begin
                if (grant_fire && tab_q[i].rank > grant_rank) dec = dec + 2'd1;
                if (ovw_fire && tab_q[i].rank > vic_rank)     dec = dec + 2'd1;
                tab_d[i].rank = tab_q[i].rank + RANK_W'(ins_fire) - RANK_W'(dec);
            end
            if (probe_fire && probe_idx == IDX_W'(i)) begin
                tab_d[i].st = SLOT_HELD;
            end
            if (grant_fire && grant_idx == IDX_W'(i)) begin
                tab_d[i].st   = SLOT_EMPTY;
                tab_d[i].rank = '0;
            end
            if (ins_fire && vic_idx == IDX_W'(i)) begin
                tab_d[i].st   = SLOT_ARMED;
                tab_d[i].blk  = ins_blk;
                tab_d[i].rank = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tab_q[i].st   <= SLOT_EMPTY;
                tab_q[i].blk  <= '0;
                tab_q[i].rank <= '0;
            end
            cancel_valid  <= 1'b0;
            cancel_qid    <= '0;
            install_valid <= 1'b0;
            install_addr  <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                tab_q[i] <= tab_d[i];
            end
            cancel_valid  <= probe_fire;
            cancel_qid    <= probe_qid;
            install_valid <= grant_fire;
            install_addr  <= {grant_blk, {OFF_W{1'b0}}};
        end
    end
endmodule

// File: rtl/ismf_checker.sv
module ismf_checker #(
    parameter int unsigned ADDR_W      = 40,
    parameter int unsigned BLOCK_BYTES = 64,
    parameter int unsigned ENTRIES     = 16,
    parameter int unsigned QID_W       = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               probe_valid,
    input logic [QID_W-1:0]   probe_qid,
    input logic               grant_valid,
    input logic [ADDR_W-1:0]  grant_addr,
    input logic               cancel_valid,
    input logic [QID_W-1:0]   cancel_qid,
    input logic               install_valid,
    input logic [ADDR_W-1:0]  install_addr,
    input logic [ENTRIES-1:0] ins_hit,
    input logic [ENTRIES-1:0] probe_hit,
    input logic [ENTRIES-1:0] grant_hit
);
    localparam int unsigned OFF_W = $clog2(BLOCK_BYTES);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cancel_valid && !install_valid));

    p_cancel_follows_probe_r2: assert property (@(posedge clk) disable iff (rst)
        cancel_valid |-> ($past(probe_valid) && cancel_qid == $past(probe_qid)));

    p_miss_no_cancel_r3: assert property (@(posedge clk) disable iff (rst)
        (probe_valid && probe_hit == '0) |=> !cancel_valid);

    p_install_follows_grant_r4: assert property (@(posedge clk) disable iff (rst)
        install_valid |-> ($past(grant_valid)
            && (install_addr >> OFF_W) == ($past(grant_addr) >> OFF_W)
            && install_addr[OFF_W-1:0] == '0));

    p_single_entry_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ins_hit) && $onehot0(probe_hit) && $onehot0(grant_hit));
endmodule

bind init_miss_filter ismf_checker #(
    .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .ENTRIES(ENTRIES), .QID_W(QID_W)
) u_ismf_checker (
    .clk(clk), .rst(rst),
    .probe_valid(probe_valid), .probe_qid(probe_qid),
    .grant_valid(grant_valid), .grant_addr(grant_addr),
    .cancel_valid(cancel_valid), .cancel_qid(cancel_qid),
    .install_valid(install_valid), .install_addr(install_addr),
    .ins_hit(ins_hit), .probe_hit(probe_hit), .grant_hit(grant_hit)
);

// File: tb/init_miss_filter_bench.sv
`timescale 1ns/1ps
module init_miss_filter_bench;
    localparam int AW = 40;
    localparam int OW = 6;
    localparam int BW = AW - OW;
    localparam int NE = 16;
    localparam int QW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          ins_valid, probe_valid, grant_valid;
    logic [AW-1:0] ins_addr, probe_addr, grant_addr;
    logic [QW-1:0] probe_qid;
    logic          cancel_valid, install_valid;
    logic [QW-1:0] cancel_qid;
    logic [AW-1:0] install_addr;

    always #2.5 clk = ~clk;

    init_miss_filter u_init_miss_filter (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_addr(ins_addr),
        .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_qid(probe_qid),
        .grant_valid(grant_valid), .grant_addr(grant_addr),
        .cancel_valid(cancel_valid), .cancel_qid(cancel_qid),
        .install_valid(install_valid), .install_addr(install_addr));

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // reference model: 0 empty, 1 armed, 2 waiting for permission
    int          m_st  [NE];
    logic [BW-1:0] m_blk [NE];
    int          m_seq [NE];
    int          seq_ctr;

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int m_find(logic [BW-1:0] b, int st);
        for (int i = 0; i < NE; i++)
            if (m_st[i] != 0 && m_blk[i] == b && (st < 0 || m_st[i] == st)) return i;
        return -1;
    endfunction

    task automatic m_clear();
        for (int i = 0; i < NE; i++) begin m_st[i] = 0; m_blk[i] = '0; m_seq[i] = 0; end
        seq_ctr = 0;
    endtask

    task automatic m_insert(logic [BW-1:0] b);
        int slot = -1;
        if (m_find(b, -1) >= 0) return;
        for (int i = 0; i < NE; i++) if (slot < 0 && m_st[i] == 0) slot = i;
        if (slot < 0)
            for (int i = 0; i < NE; i++)
                if (m_st[i] == 1 && (slot < 0 || m_seq[i] < m_seq[slot])) slot = i;
        if (slot < 0) return;
        m_st[slot] = 1; m_blk[slot] = b; m_seq[slot] = seq_ctr++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ins_valid = 0; probe_valid = 0; grant_valid = 0;
        ins_addr = '0; probe_addr = '0; grant_addr = '0; probe_qid = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_clear();
        @(negedge clk);
    endtask

    // kind: 0 idle, 1 insert, 2 probe, 3 grant. Called just after a falling edge.
    task automatic do_op(int kind, logic [BW-1:0] b, logic [OW-1:0] off,
                         logic [QW-1:0] qid, string tag);
        bit ec = 0, ei = 0;
        int k;
        ins_valid = (kind == 1); probe_valid = (kind == 2); grant_valid = (kind == 3);
        ins_addr = {b, off}; probe_addr = {b, off}; grant_addr = {b, off}; probe_qid = qid;
        if (kind == 1) m_insert(b);
        if (kind == 2) begin
            k = m_find(b, 1);
            if (k >= 0) begin ec = 1; m_st[k] = 2; end
        end
        if (kind == 3) begin
            k = m_find(b, 2);
            if (k >= 0) begin ei = 1; m_st[k] = 0; end
        end
        @(negedge clk);
        ins_valid = 0; probe_valid = 0; grant_valid = 0;
        chk(tag, "cancel_valid", longint'(cancel_valid), longint'(ec));
        if (ec) chk(tag, "cancel_qid", longint'(cancel_qid), longint'(qid));
        chk(tag, "install_valid", longint'(install_valid), longint'(ei));
        if (ei) chk(tag, "install_addr", longint'(install_addr), longint'({b, 6'b0}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d));
        do_reset();

        // R1: quiet after reset, nothing stored
        chk("R1", "cancel_valid", longint'(cancel_valid), 0);
        chk("R1", "install_valid", longint'(install_valid), 0);
        do_op(2, 34'd5, 6'd0, 6'd1, "R1");

        // R2 / R11: match at block level, any offset
        do_op(1, 34'd7, 6'd3, 6'd0, "R2");
        do_op(2, 34'd7, 6'd60, 6'd9, "R11");
        // R3 / R11: neighbouring block does not match
        do_op(1, 34'd8, 6'd0, 6'd0, "R3");
        do_op(2, 34'd9, 6'd8, 6'd2, "R11");
        do_op(2, 34'd9, 6'd8, 6'd2, "R3");
        // R6: waiting entry ignores another probe
        do_op(2, 34'd7, 6'd1, 6'd4, "R6");
        do_op(0, 34'd0, 6'd0, 6'd0, "R4");
        // R4: grant releases the install
        do_op(3, 34'd7, 6'd17, 6'd0, "R4");
        // R5: entry gone after install
        do_op(2, 34'd7, 6'd0, 6'd5, "R5");
        // R10: grant for an armed block does nothing; block still armed
        do_op(3, 34'd8, 6'd0, 6'd0, "R10");
        do_op(2, 34'd8, 6'd4, 6'd6, "R10");

        // R8: overfill armed table, oldest is replaced
        do_reset();
        for (int i = 0; i < NE; i++) do_op(1, BW'(40 + i), 6'd0, 6'd0, "R8");
        do_op(1, 34'd56, 6'd0, 6'd0, "R8");
        do_op(2, 34'd40, 6'd0, 6'd10, "R8");
        do_op(2, 34'd41, 6'd0, 6'd11, "R8");
        do_op(2, 34'd56, 6'd0, 6'd12, "R8");

        // R7: duplicate insert does not consume a slot or refresh age
        do_reset();
        do_op(1, 34'd20, 6'd0, 6'd0, "R7");
        do_op(1, 34'd20, 6'd9, 6'd0, "R7");
        for (int i = 1; i < NE; i++) do_op(1, BW'(20 + i), 6'd0, 6'd0, "R7");
        do_op(2, 34'd35, 6'd0, 6'd13, "R7");
        do_op(1, 34'd20, 6'd0, 6'd0, "R7");
        do_op(1, 34'd50, 6'd0, 6'd0, "R7");
        do_op(2, 34'd20, 6'd0, 6'd14, "R7");
        do_op(2, 34'd21, 6'd0, 6'd15, "R7");

        // R9: all slots waiting -> insert dropped, waiting entries kept
        do_reset();
        for (int i = 0; i < NE; i++) do_op(1, BW'(60 + i), 6'd0, 6'd0, "R9");
        for (int i = 0; i < NE; i++) do_op(2, BW'(60 + i), 6'd0, QW'(i), "R9");
        do_op(1, 34'd99, 6'd0, 6'd0, "R9");
        do_op(2, 34'd99, 6'd0, 6'd30, "R9");
        do_op(3, 34'd60, 6'd0, 6'd0, "R9");
        do_op(3, 34'd75, 6'd0, 6'd0, "R9");
        do_op(1, 34'd99, 6'd0, 6'd0, "R9");
        do_op(2, 34'd99, 6'd0, 6'd31, "R9");

        // random mix over a pool slightly larger than the table
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            int kind = int'($urandom_range(0, 3));
            logic [BW-1:0] b = BW'($urandom_range(100, 123));
            logic [OW-1:0] o = OW'($urandom);
            logic [QW-1:0] q = QW'($urandom);
            case (kind)
                1: do_op(1, b, o, q, "R8");
                2: do_op(2, b, o, q, "R2");
                3: do_op(3, b, o, q, "R4");
                default: do_op(0, b, o, q, "R3");
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule